// File: doc/BRIEF.md
# Multichannel PCM Prompt Playback Buffer

This block holds prompt audio for a set of playback channels and places each channel's bytes on a time slot of a frame-synchronous TDM PCM bus. Each channel owns a 32-byte region of one shared byte store. The region is split into two 16-byte halves that are used in turn. Host firmware fills one half while the bus side drains the other. One byte per enabled channel leaves in every frame, which matches the 64 kbps rate of 8-bit PCM at an 8 kHz frame rate.

The host reaches the block through a single write port, and the operation code on that port selects what a write does. It can load a sample byte, set a channel's target slot, allocate or release a channel, or set how many ports are in service, in groups of 8. The channels appear on the bus as a block of consecutive port addresses that starts at `base_addr`. A status view for one selected channel shows whether the channel is enabled, which halves hold data, and whether the channel has run dry. Firmware attaches a channel to a voice path for the length of a prompt and releases it afterwards.

Top module: `pcm_prompt_player`

## Requirements
- R1: After reset no channel is enabled, `pcm_oe` is 0, and every channel shows both halves empty with no underrun. All ports are in service after reset.
- R2: Each enabled channel sends one byte per frame, in its own slot. Bytes leave in offset order 0 to 31 and then wrap to offset 0, so the lower half (offsets 0-15) drains before the upper half (offsets 16-31).
- R3: A channel can target any slot from 0 to NSLOT-1, set by operation 1 with the slot number in `wr_data`. While a channel drives its slot, `pcm_port` equals `base_addr` plus the channel number.
- R4: Operation 0 writes `wr_data` at offset `wr_ofs` of channel `wr_chan`. A write to offset 15 marks the lower half full, and a write to offset 31 marks the upper half full. A half is marked empty once its last byte has been sent. `st_full` bit 0 shows the lower half and bit 1 the upper half.
- R5: When a channel's slot comes and its current half is empty, the block sends 0xFF with `pcm_oe` high. It also sets the channel's underrun flag, which stays set until the channel is next written with operation 2.
- R6: A disabled channel never drives the bus. Data loaded into it does not reach the output.
- R7: A slot written with operation 1 takes effect from the next frame start (`frame_sync` together with `slot_en`). Until then the channel keeps its previous slot.
- R8: When several enabled channels target the same slot, only the lowest-numbered channel drives it, and only that channel's buffer advances.
- R9: Operation 3 sets the number of ports in service to 8 times `wr_data`, capped at the channel count. Channels at or above the new limit are released. An operation-2 enable of a channel at or above the limit is refused.
- R10: Operation 2 with `wr_data[0]`=1 allocates a channel and resets its read position to offset 0. The same operation with `wr_data[0]`=0 releases the channel. Either form clears the channel's full and underrun flags.
- R11: `pcm_oe` is high only in the cycle after a slot strobe (`slot_en`=1). The slot number is 0 on a strobe that has `frame_sync` set, and otherwise one more than the previous slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_op | input | 2 | 0 byte, 1 slot, 2 allocate/release, 3 port limit |
| wr_chan | input | CW | Channel addressed by the write |
| wr_ofs | input | 5 | Byte offset within the channel region |
| wr_data | input | 8 | Write payload |
| base_addr | input | PA_W | First port address of the block |
| frame_sync | input | 1 | With slot_en, marks slot 0 |
| slot_en | input | 1 | One bus slot per strobe |
| st_chan | input | CW | Channel shown on the status outputs |
| st_en | output | 1 | Selected channel enabled |
| st_full | output | 2 | Selected channel half-full flags |
| st_und | output | 1 | Selected channel sticky underrun |
| pcm_oe | output | 1 | Bus drive enable |
| pcm_data | output | 8 | Byte on the bus |
| pcm_port | output | PA_W | Port address of the driving channel |

## Verification
Several properties are checked by assertions on every cycle. The output is driven only just after a slot strobe. No enabled channel sits above the port limit. The active slot table changes only at a frame start. An underrun is sticky until an allocate or release write clears it. Every new underrun coincides with 0xFF on the bus. Other behaviour needs the bench's scenarios. These cover byte order across the two halves, refilling a half while the other half plays, and a retarget that waits for the next frame. They also cover a shared slot won by the lower channel, and refused or revoked allocations after the limit shrinks.

// File: rtl/pcm_prompt_player.sv
module pcm_prompt_player #(
  parameter int NCH   = 32,
  parameter int NSLOT = 128,
  parameter int PA_W  = 11,
  localparam int CW   = $clog2(NCH),
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_op,
  input  logic [CW-1:0]   wr_chan,
  input  logic [4:0]      wr_ofs,
  input  logic [7:0]      wr_data,
  input  logic [PA_W-1:0] base_addr,
  input  logic            frame_sync,
  input  logic            slot_en,
  input  logic [CW-1:0]   st_chan,
  output logic            st_en,
  output logic [1:0]      st_full,
  output logic            st_und,
  output logic            pcm_oe,
  output logic [7:0]      pcm_data,
  output logic [PA_W-1:0] pcm_port
);
  localparam int AW   = CW + 5;
  localparam int NGRP = NCH / 8;

  logic [7:0] mem [NCH*32];
  logic [NCH-1:0] en, und, full_lo, full_hi;
  logic [4:0] ptr [NCH];
  logic [NCH-1:0][SW-1:0] act, pend;
  logic [7:0] lim;
  logic [SW-1:0] slot_cnt, cur_slot;
  logic frame_start, hit, ready, chan_ok;
  logic [CW-1:0] win;
  logic [7:0] new_lim;
  logic [NCH-1:0] clr_mask;

  assign frame_start = slot_en & frame_sync;
  assign cur_slot    = frame_sync ? '0 : slot_cnt + 1'b1;
  assign chan_ok     = int'(wr_chan) < int'(lim) * 8;
  assign new_lim     = (int'(wr_data) > NGRP) ? 8'(NGRP) : wr_data;

  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (en[c] && ((frame_start ? pend[c] : act[c]) == cur_slot)) begin
        hit = 1'b1;
        win = CW'(c);
      end
    end
    ready = ptr[win][4] ? full_hi[win] : full_lo[win];
  end

  always_comb begin
    clr_mask = '0;
    if (wr_en && wr_op == 2'd2) clr_mask[wr_chan] = 1'b1;
  end

  assign st_en   = en[st_chan];
  assign st_full = {full_hi[st_chan], full_lo[st_chan]};
  assign st_und  = und[st_chan];

  always_ff @(posedge clk) begin
    if (wr_en && wr_op == 2'd0) mem[{wr_chan, wr_ofs}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      lim      <= 8'(NGRP);
      pcm_oe   <= 1'b0;
      pcm_data <= 8'hFF;
      pcm_port <= '0;
    end else begin
      if (slot_en) slot_cnt <= cur_slot;
      if (wr_en && wr_op == 2'd3) lim <= new_lim;
      pcm_oe   <= slot_en && hit;
      pcm_data <= ready ? mem[AW'({win, ptr[win]})] : 8'hFF;
      pcm_port <= base_addr + PA_W'(win);
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        en[c]      <= 1'b0;
        und[c]     <= 1'b0;
        full_lo[c] <= 1'b0;
        full_hi[c] <= 1'b0;
        ptr[c]     <= '0;
        act[c]     <= '0;
        pend[c]    <= '0;
      end else begin
        if (slot_en && hit && win == CW'(c)) begin
          if (ready) begin
            ptr[c] <= ptr[c] + 5'd1;
            if (ptr[c][3:0] == 4'hF) begin
              if (ptr[c][4]) full_hi[c] <= 1'b0;
              else           full_lo[c] <= 1'b0;
            end
          end else begin
            und[c] <= 1'b1;
          end
        end
        if (frame_start) act[c] <= pend[c];
        if (wr_en && wr_chan == CW'(c)) begin
          case (wr_op)
            2'd0: if (wr_ofs[3:0] == 4'hF) begin
                    if (wr_ofs[4]) full_hi[c] <= 1'b1;
                    else           full_lo[c] <= 1'b1;
                  end
            2'd1: pend[c] <= wr_data[SW-1:0];
            2'd2: begin
                    en[c]      <= wr_data[0] & chan_ok;
                    und[c]     <= 1'b0;
                    full_lo[c] <= 1'b0;
                    full_hi[c] <= 1'b0;
                    ptr[c]     <= '0;
                  end
            default: ;
          endcase
        end
        if (wr_en && wr_op == 2'd3 && c >= int'(new_lim) * 8) en[c] <= 1'b0;
      end
    end
  end

  // R11
  oe_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> $past(slot_en));

  // R7
  slot_table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(act));

  // R5
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(und) & ~$past(clr_mask) & ~und) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R9
    en_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en[g] && (g >= int'(lim) * 8)));
    // R5
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(und[g]) |-> (pcm_oe && pcm_data == 8'hFF));
  end
endmodule

// File: tb/test_pcm_prompt_player.sv
module test_pcm_prompt_player;
  localparam int NCH = 32, NSLOT = 128, PA_W = 11, CW = 5;
  localparam logic [PA_W-1:0] BASE = 11'd300;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [1:0] wr_op = 0; logic [CW-1:0] wr_chan = 0;
  logic [4:0] wr_ofs = 0; logic [7:0] wr_data = 0;
  logic frame_sync = 0, slot_en = 0;
  logic [CW-1:0] st_chan = 0;
  logic st_en, st_und, pcm_oe; logic [1:0] st_full;
  logic [7:0] pcm_data; logic [PA_W-1:0] pcm_port;
  int checks = 0, errors = 0;
  logic [18:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  pcm_prompt_player #(.NCH(NCH), .NSLOT(NSLOT), .PA_W(PA_W)) i_pcm_prompt_player (
    .clk, .rst_n, .wr_en, .wr_op, .wr_chan, .wr_ofs, .wr_data, .base_addr(BASE),
    .frame_sync, .slot_en, .st_chan, .st_en, .st_full, .st_und,
    .pcm_oe, .pcm_data, .pcm_port);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_byte(input int ch, input logic [7:0] d);
    exp_q.push_back({d, BASE + PA_W'(ch)});
  endtask

  always @(negedge clk) if (rst_n && pcm_oe) begin
    if (exp_q.size() == 0) chk(0, "R6 unexpected drive", {pcm_data, pcm_port}, 0);
    else begin
      logic [18:0] e;
      e = exp_q.pop_front();
      chk(pcm_data == e[18:11], "R2 byte", pcm_data, e[18:11]);
      chk(pcm_port == e[10:0], "R3 port", pcm_port, e[10:0]);
    end
  end

  task automatic host(input logic [1:0] op, input int ch, input int ofs, input logic [7:0] d);
    wr_en = 1; wr_op = op; wr_chan = CW'(ch); wr_ofs = 5'(ofs); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic status(input int ch, input bit e, input logic [1:0] f, input bit u, input string req);
    st_chan = CW'(ch); #1;
    chk(st_en == e, {req, " enable"}, st_en, e);
    chk(st_full == f, {req, " full"}, st_full, f);
    chk(st_und == u, {req, " underrun"}, st_und, u);
  endtask

  task automatic run_frame(input int mid_s, input int ch, input logic [7:0] d);
    for (int s = 0; s < NSLOT; s++) begin
      slot_en = 1; frame_sync = (s == 0);
      if (s == mid_s) begin
        wr_en = 1; wr_op = 2'd1; wr_chan = CW'(ch); wr_data = d;
      end
      @(posedge clk); #1;
      wr_en = 0;
    end
    slot_en = 0; frame_sync = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(pcm_oe == 0, "R1 oe", pcm_oe, 0);
    status(3, 0, 2'b00, 0, "R1");
    // R10 allocate clears position and flags
    host(2'd2, 3, 0, 8'd1);
    status(3, 1, 2'b00, 0, "R10");
    host(2'd1, 3, 0, 8'd10);
    for (int i = 0; i < 32; i++) host(2'd0, 3, i, 8'h40 + 8'(i));
    status(3, 1, 2'b11, 0, "R4 load");
    host(2'd2, 4, 0, 8'd1);
    host(2'd1, 4, 0, 8'd10);
    for (int i = 0; i < 32; i++) host(2'd0, 4, i, 8'h80 + 8'(i));
    // R6 loaded then released channel stays silent
    host(2'd2, 7, 0, 8'd1);
    host(2'd1, 7, 0, 8'd20);
    for (int i = 0; i < 32; i++) host(2'd0, 7, i, 8'h11);
    host(2'd2, 7, 0, 8'd0);
    status(7, 0, 2'b00, 0, "R6");
    // R2 R8 sixteen frames, ch3 beats ch4 on slot 10
    for (int f = 0; f < 16; f++) expect_byte(3, 8'h40 + 8'(f));
    for (int f = 0; f < 16; f++) run_frame(-1, 0, 0);
    status(3, 1, 2'b10, 0, "R4 lower drained");
    status(4, 1, 2'b11, 0, "R8 loser untouched");
    // R4 refill the lower half while the upper plays
    for (int i = 0; i < 16; i++) host(2'd0, 3, i, 8'hC0 + 8'(i));
    status(3, 1, 2'b11, 0, "R4 refill");
    // R7 retarget mid-frame, applies next frame; R3 slot 50
    expect_byte(3, 8'h50);
    run_frame(30, 3, 8'd50);
    expect_byte(4, 8'h80);
    expect_byte(3, 8'h51);
    run_frame(-1, 0, 0);
    host(2'd2, 4, 0, 8'd0);
    for (int f = 0; f < 14; f++) expect_byte(3, 8'h52 + 8'(f));
    for (int f = 0; f < 16; f++) expect_byte(3, 8'hC0 + 8'(f));
    for (int f = 0; f < 30; f++) run_frame(-1, 0, 0);
    status(3, 1, 2'b00, 0, "R2 drained");
    // R5 underrun sends idle code and sticks
    expect_byte(3, 8'hFF);
    run_frame(-1, 0, 0);
    status(3, 1, 2'b00, 1, "R5 set");
    expect_byte(3, 8'hFF);
    run_frame(-1, 0, 0);
    status(3, 1, 2'b00, 1, "R5 sticky");
    // R9 port limit
    host(2'd2, 9, 0, 8'd1);
    host(2'd1, 9, 0, 8'd60);
    for (int i = 0; i < 32; i++) host(2'd0, 9, i, 8'h22);
    status(9, 1, 2'b11, 0, "R9 before limit");
    host(2'd3, 0, 0, 8'd1);
    status(9, 0, 2'b11, 0, "R9 released");
    status(3, 1, 2'b00, 1, "R9 kept");
    host(2'd2, 12, 0, 8'd1);
    status(12, 0, 2'b00, 0, "R9 refused");
    expect_byte(3, 8'hFF);
    run_frame(-1, 0, 0);
    chk(exp_q.size() == 0, "R11 pending outputs", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) chk(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule